// File: doc/BRIEF.md
# Lane-Packed Narrow Memory

This block looks, from outside, like a deep and narrow memory with one write port and one read port. Inside, it keeps the bits in a shallow and wide array with a mask on each write. The low bits of each narrow address pick a lane inside a wide row. The remaining high bits pick the row. A write places the narrow word in its lane and sets only that lane's mask bit, so the rest of the row keeps its contents. A read fetches the whole row one cycle later and returns the addressed lane.

The inner masked array is a plain behavioural model held in the same module. Each port has its own clock and enable. The wide word must hold a whole number of lanes, and that number must be a power of two and at least two. The default is a 2-bit by 256-entry view over an 8-bit by 64-row array, which gives four lanes with a mask granule of 2 bits.

Top module: `lane_packed_ram`

## Requirements
- R1: While `rst_n` is low, the read output register is cleared. After reset, `rd_data` is 0 until the first read completes.
- R2: A write with `wr_en` high stores `wr_data` at narrow address `wr_addr`. The lane is `wr_addr[LANE_BITS-1:0]` and the row is `wr_addr[ADDR_W-1:LANE_BITS]`. A later read of that address returns the stored value.
- R3: A write changes only its own lane. The other lanes of the same row, and all other rows, keep their values.
- R4: When `rd_en` is high at a `rd_clk` edge, the value at `rd_addr` appears on `rd_data` after that edge. Reads may be issued on every cycle, one value per edge.
- R5: While `rd_en` is low, `rd_data` holds its last value, even when `rd_addr` changes or the same location is written.
- R6: While `wr_en` is low, the stored contents do not change, whatever `wr_addr` and `wr_data` carry.
- R7: When a read and a write hit the same address at the same clock edge, the read returns the value held before that write.
- R8: Each write asserts exactly one bit of the inner lane mask, which is the bit for the written lane.
- R9: Address 0 maps to row 0, lane 0. Address DEPTH-1 maps to the last row, last lane. Both behave like any other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write port clock |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Narrow write address |
| wr_data | input | NARROW_W | Narrow write data |
| rd_clk | input | 1 | Read port clock |
| rst_n | input | 1 | Active-low synchronous reset of the read output register (rd_clk domain) |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Narrow read address |
| rd_data | output | NARROW_W | Narrow read data, one cycle after the read |

## Verification
The bench builds the block with its default parameters: a 2-bit narrow word, 256 entries and an 8-bit inner row. That gives four lanes over 64 rows. With this size, every address can be written and read back in a few hundred cycles, so every lane of every row and both address extremes are checked against a flat narrow reference array. Four lanes per row also make it possible to check lane isolation on a middle lane, whose neighbours lie on both sides. Both ports run from one clock, so a read and a write can hit the same address at the same edge.

// File: rtl/lane_packed_ram.sv
module lane_packed_ram #(
  parameter int NARROW_W = 2,
  parameter int DEPTH    = 256,
  parameter int WIDE_W   = 8
) (
  input  logic                              wr_clk,
  input  logic                              wr_en,
  input  logic [$clog2(DEPTH)-1:0]          wr_addr,
  input  logic [NARROW_W-1:0]               wr_data,
  input  logic                              rd_clk,
  input  logic                              rst_n,
  input  logic                              rd_en,
  input  logic [$clog2(DEPTH)-1:0]          rd_addr,
  output logic [NARROW_W-1:0]               rd_data
);
  localparam int LANES     = WIDE_W / NARROW_W;
  localparam int LANE_BITS = $clog2(LANES);
  localparam int ADDR_W    = $clog2(DEPTH);
  localparam int ROWS      = DEPTH / LANES;
  localparam int ROW_BITS  = ADDR_W - LANE_BITS;

  logic [ROWS-1:0][WIDE_W-1:0] rows;
  logic [LANE_BITS-1:0]        wr_lane, rd_lane, rd_lane_q;
  logic [ROW_BITS-1:0]         wr_row, rd_row;
  logic [LANES-1:0]            wr_mask;
  logic [WIDE_W-1:0]           wide_wdata, row_q;

  assign wr_lane    = wr_addr[LANE_BITS-1:0];
  assign wr_row     = wr_addr[ADDR_W-1:LANE_BITS];
  assign rd_lane    = rd_addr[LANE_BITS-1:0];
  assign rd_row     = rd_addr[ADDR_W-1:LANE_BITS];
  assign wr_mask    = LANES'(1) << wr_lane;
  assign wide_wdata = WIDE_W'(wr_data) << (NARROW_W * int'(wr_lane));

  always_ff @(posedge wr_clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_mask[l]) rows[wr_row][l*NARROW_W +: NARROW_W] <= wide_wdata[l*NARROW_W +: NARROW_W];
      end
    end
  end

  always_ff @(posedge rd_clk) begin
    if (!rst_n) begin
      row_q     <= '0;
      rd_lane_q <= '0;
    end else if (rd_en) begin
      row_q     <= rows[rd_row];
      rd_lane_q <= rd_lane;
    end
  end

  assign rd_data = row_q[NARROW_W*int'(rd_lane_q) +: NARROW_W];
endmodule

// File: rtl/lane_packed_ram_chk.sv
module lane_packed_ram_chk #(
  parameter int NARROW_W = 2,
  parameter int DEPTH    = 256,
  parameter int WIDE_W   = 8
) (
  input logic                                           wr_clk,
  input logic                                           rd_clk,
  input logic                                           rst_n,
  input logic                                           wr_en,
  input logic                                           rd_en,
  input logic [$clog2(DEPTH)-1:0]                       rd_addr,
  input logic [NARROW_W-1:0]                            rd_data,
  input logic [WIDE_W/NARROW_W-1:0]                     wr_mask,
  input logic [$clog2(WIDE_W/NARROW_W)-1:0]             rd_lane_q,
  input logic [DEPTH/(WIDE_W/NARROW_W)-1:0][WIDE_W-1:0] rows
);
  localparam int LB = $clog2(WIDE_W / NARROW_W);

  AST_ONE_LANE_MASK: assert property (@(posedge wr_clk) disable iff (!rst_n) wr_en |-> $countones(wr_mask) == 1); // R8
  AST_NO_WRITE_NO_CHANGE: assert property (@(posedge wr_clk) disable iff (!rst_n) !wr_en |=> $stable(rows)); // R6
  AST_RD_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n) !rd_en |=> $stable(rd_data)); // R5
  AST_LANE_CAPTURE: assert property (@(posedge rd_clk) disable iff (!rst_n) rd_en |=> rd_lane_q == $past(rd_addr[LB-1:0])); // R4
endmodule

bind lane_packed_ram lane_packed_ram_chk #(.NARROW_W(NARROW_W), .DEPTH(DEPTH), .WIDE_W(WIDE_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .rd_addr(rd_addr), .rd_data(rd_data), .wr_mask(wr_mask), .rd_lane_q(rd_lane_q), .rows(rows)
);

// File: tb/lane_packed_ram_test.sv
module lane_packed_ram_test;
  localparam int NW = 2, DEPTH = 256, WW = 8, AW = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [NW-1:0] wr_data = '0, rd_data;
  logic [NW-1:0] ref_mem [DEPTH];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lane_packed_ram #(.NARROW_W(NW), .DEPTH(DEPTH), .WIDE_W(WW)) uut (
    .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(string req, logic [NW-1:0] act, logic [NW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(int a, logic [NW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 0; ref_mem[a] = d;
  endtask

  task automatic do_read(int a, string req);
    @(negedge clk); rd_en = 1; rd_addr = AW'(a);
    @(negedge clk); rd_en = 0;
    check(req, rd_data, ref_mem[a]);
  endtask

  task automatic t_reset;
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 reset output", rd_data, '0);
  endtask

  task automatic t_fill_all;
    for (int a = 0; a < DEPTH; a++) do_write(a, NW'((a * 3) ^ (a >> 2)));
    @(negedge clk); rd_en = 1; rd_addr = 0;
    for (int a = 1; a <= DEPTH; a++) begin
      @(negedge clk);
      check("R2/R4 back-to-back read", rd_data, ref_mem[a-1]);
      if (a < DEPTH) rd_addr = AW'(a); else rd_en = 0;
    end
  endtask

  task automatic t_isolation;
    int base = 4 * 37;
    for (int l = 0; l < 4; l++) do_write(base + l, NW'(l));
    do_write(base + 1, 2'b10);
    do_write(base + 2, 2'b01);
    for (int l = 0; l < 4; l++) do_read(base + l, "R3 lane isolation");
    do_read(base - 1, "R3 neighbour row");
    do_read(base + 4, "R3 neighbour row");
  endtask

  task automatic t_no_write;
    @(negedge clk); wr_en = 0; wr_addr = 8'd9; wr_data = ~ref_mem[9];
    repeat (2) @(negedge clk);
    do_read(9, "R6 write disabled");
  endtask

  task automatic t_hold;
    logic [NW-1:0] v;
    do_read(20, "R4 single read");
    v = ref_mem[20];
    @(negedge clk); rd_addr = 8'd21;
    do_write(20, ~v);
    repeat (2) @(negedge clk);
    check("R5 hold with rd_en low", rd_data, v);
  endtask

  task automatic t_collision;
    logic [NW-1:0] old = ref_mem[50];
    @(negedge clk); wr_en = 1; wr_addr = 8'd50; wr_data = ~old; rd_en = 1; rd_addr = 8'd50;
    @(negedge clk); wr_en = 0; rd_en = 0; ref_mem[50] = ~old;
    check("R7 read-during-write old data", rd_data, old);
    do_read(50, "R7 new data after collision");
  endtask

  task automatic t_extremes;
    do_write(0, 2'b11);
    do_write(DEPTH - 1, 2'b10);
    do_write(1, 2'b00);
    do_write(DEPTH - 2, 2'b01);
    do_read(0, "R9 address zero");
    do_read(DEPTH - 1, "R9 top address");
    do_read(1, "R9 lane next to zero");
    do_read(DEPTH - 2, "R9 lane next to top");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill_all();
    t_isolation();
    t_no_write();
    t_hold();
    t_collision();
    t_extremes();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule